// File: doc/BRIEF.md
# Location catalog with vector-table dispatch

This block is a small hardware catalog that records where each item is kept. A storage area is organised as shelves with several racks on each shelf; every shelf/rack pair is one location. Each catalog entry is keyed by a unique 8-bit catalog number and holds that item's current location as a compact vector number. The vector is (shelf-1)*RACKS + rack, so with the default 3x3 layout it runs from 1 to 9, and 0 means "not located".

A write port stores or moves an item. A new catalog number claims the lowest free entry. A known catalog number has its entry rewritten in place, so later lookups return the new location. A query port takes a catalog number and answers one cycle later with a done pulse. The answer carries the shelf, the rack and a handler-table entry address. That address is a fixed base (0xFFF00000) plus the vector times four, because each table slot is four bytes in a byte-addressed space. A write and a query in the same cycle for the same number are ordered write-first.

Top module: `loc_catalog`

## Requirements
- R1: After reset, done, not_found and wr_reject are 0, shelf_o, rack_o and addr_o are 0, and the catalog is empty, so any query reports not_found.
- R2: A write of a catalog number that is not present, with shelf and rack each in 1..3, is accepted (no wr_reject) while fewer than 16 numbers are held. A later query returns that shelf and rack.
- R3: A write of a catalog number already present replaces its location without using a new entry. This works even when all 16 entries are in use, and later queries return the new location.
- R4: For a found item, addr_o = 0xFFF00000 + 4*V where V = (shelf-1)*3 + rack. Location (1,1) gives 0xFFF00004, (1,2) gives 0xFFF00008, and (3,3) gives 0xFFF00024.
- R5: Every cycle with q_en high produces done high in the following cycle. done is low in a cycle that follows a cycle without q_en.
- R6: If no held entry matches the queried number, not_found is 1 alongside done, and shelf_o, rack_o and addr_o are 0.
- R7: A write and a query for the same number in the same cycle answer with the written location, provided the write is accepted.
- R8: A write of a new number while all 16 entries are held is refused: wr_reject is 1 in the next cycle and the number stays absent.
- R9: A write whose shelf or rack is outside 1..3 is refused with wr_reject in the next cycle, and any stored location of that number is unchanged.
- R10: shelf_o, rack_o, addr_o and not_found keep their values in cycles that follow a cycle without q_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Store or move request |
| wr_key | input | 8 | Catalog number to store |
| wr_shelf | input | 2 | Shelf, 1..3 |
| wr_rack | input | 2 | Rack, 1..3 |
| q_en | input | 1 | Lookup request |
| q_key | input | 8 | Catalog number to look up |
| done | output | 1 | One-cycle answer strobe |
| not_found | output | 1 | Queried number absent |
| shelf_o | output | 2 | Shelf of the found item |
| rack_o | output | 2 | Rack of the found item |
| addr_o | output | 32 | Handler-table entry address |
| wr_reject | output | 1 | Previous write refused |

## Verification
The hardest situation to reach is a full catalog. In that state a brand-new number is refused, an existing number may still be moved, and a same-cycle write and query for a new number must still miss. The stimulus reaches it by filling all sixteen entries with distinct numbers through ordinary writes. It then issues the refused write, an in-place move and a combined write-plus-query, and checks each answer at the ports.

// File: rtl/loc_catalog_pkg.sv
`timescale 1ns/1ps
package loc_catalog_pkg;
   // Vector number of a location; 0 is reserved for "not located".
   function automatic int unsigned loc_vector(input int unsigned shelf,
                                              input int unsigned rack,
                                              input int unsigned racks);
      return (shelf - 1) * racks + rack;
   endfunction

   // Bits needed to hold values 0..n.
   function automatic int unsigned bits_for(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/loc_vec_enc.sv
`timescale 1ns/1ps
module loc_vec_enc
   import loc_catalog_pkg::*;
#(
   parameter int unsigned SHELVES = 3,
   parameter int unsigned RACKS   = 3,
   parameter int unsigned SH_W    = 2,
   parameter int unsigned RK_W    = 2,
   parameter int unsigned VEC_W   = 4
) (
   input  logic [SH_W-1:0]  shelf_in,
   input  logic [RK_W-1:0]  rack_in,
   output logic             loc_ok,
   output logic [VEC_W-1:0] vec_out
);
   always_comb begin
      loc_ok  = (int'(shelf_in) >= 1) && (int'(shelf_in) <= int'(SHELVES)) &&
                (int'(rack_in)  >= 1) && (int'(rack_in)  <= int'(RACKS));
      vec_out = '0;
      if (loc_ok)
         vec_out = VEC_W'(loc_vector(int'(shelf_in), int'(rack_in), RACKS));
   end
endmodule

// File: rtl/loc_vec_dec.sv
`timescale 1ns/1ps
module loc_vec_dec
   import loc_catalog_pkg::*;
#(
   parameter int unsigned        SHELVES = 3,
   parameter int unsigned        RACKS   = 3,
   parameter int unsigned        SH_W    = 2,
   parameter int unsigned        RK_W    = 2,
   parameter int unsigned        VEC_W   = 4,
   parameter int unsigned        ADDR_W  = 32,
   parameter int unsigned        SLOT_LG = 2,
   parameter logic [ADDR_W-1:0]  BASE    = 32'hFFF0_0000
) (
   input  logic [VEC_W-1:0]  vec_in,
   output logic [SH_W-1:0]   shelf_out,
   output logic [RK_W-1:0]   rack_out,
   output logic [ADDR_W-1:0] addr_out
);
   always_comb begin
      shelf_out = '0;
      rack_out  = '0;
      for (int s = 1; s <= int'(SHELVES); s++) begin
         for (int r = 1; r <= int'(RACKS); r++) begin
            if (vec_in == VEC_W'(loc_vector(s, r, RACKS))) begin
               shelf_out = SH_W'(s);
               rack_out  = RK_W'(r);
            end
         end
      end
   end

   // A slot size of one byte needs no shift; otherwise shift by the slot width.
   generate
      if (SLOT_LG == 0) begin : g_byte_slots
         assign addr_out = BASE + ADDR_W'(vec_in);
      end else begin : g_wide_slots
         assign addr_out = BASE + (ADDR_W'(vec_in) << SLOT_LG);
      end
   endgenerate
endmodule

// File: rtl/loc_cat_store.sv
`timescale 1ns/1ps
module loc_cat_store #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned KEY_W = 8,
   parameter int unsigned VEC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [KEY_W-1:0] wr_key,
   input  logic [VEC_W-1:0] wr_vec,
   input  logic             wr_loc_ok,
   input  logic [KEY_W-1:0] q_key,
   output logic             wr_accept,
   output logic             q_hit,
   output logic [VEC_W-1:0] q_vec
);
   localparam int unsigned IDX_W = (DEPTH < 2) ? 1 : $clog2(DEPTH);

   logic [DEPTH-1:0] valid_q;
   logic [KEY_W-1:0] key_q [DEPTH];
   logic [VEC_W-1:0] vec_q [DEPTH];

   logic [DEPTH-1:0] wr_match;
   logic [DEPTH-1:0] q_match;
   logic [IDX_W-1:0] free_idx;
   logic             any_free;
   logic             wr_hit;
   logic             bypass;
   logic [VEC_W-1:0] stored_vec;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_entry
         assign wr_match[i] = valid_q[i] && (key_q[i] == wr_key);
         assign q_match[i]  = valid_q[i] && (key_q[i] == q_key);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               valid_q[i] <= 1'b0;
               key_q[i]   <= '0;
               vec_q[i]   <= '0;
            end else if (wr_accept &&
                         (wr_match[i] || (!wr_hit && free_idx == IDX_W'(i)))) begin
               valid_q[i] <= 1'b1;
               key_q[i]   <= wr_key;
               vec_q[i]   <= wr_vec;
            end
         end
      end
   endgenerate

   // Lowest free entry: scan downward so the smallest index wins.
   always_comb begin
      free_idx = '0;
      for (int i = int'(DEPTH) - 1; i >= 0; i--) begin
         if (!valid_q[i]) free_idx = IDX_W'(i);
      end
   end

   always_comb begin
      stored_vec = '0;
      for (int i = 0; i < int'(DEPTH); i++) begin
         if (q_match[i]) stored_vec = stored_vec | vec_q[i];
      end
   end

   assign any_free  = ~&valid_q;
   assign wr_hit    = |wr_match;
   assign wr_accept = wr_en && wr_loc_ok && (wr_hit || any_free);
   assign bypass    = wr_accept && (wr_key == q_key);
   assign q_hit     = bypass || (|q_match);
   assign q_vec     = bypass ? wr_vec : stored_vec;
endmodule

// File: rtl/loc_catalog.sv
`timescale 1ns/1ps
module loc_catalog
   import loc_catalog_pkg::*;
#(
   parameter int unsigned       SHELVES = 3,
   parameter int unsigned       RACKS   = 3,
   parameter int unsigned       DEPTH   = 16,
   parameter int unsigned       KEY_W   = 8,
   parameter int unsigned       ADDR_W  = 32,
   parameter int unsigned       SLOT_LG = 2,
   parameter logic [ADDR_W-1:0] BASE    = 32'hFFF0_0000,
   localparam int unsigned      SH_W    = bits_for(SHELVES),
   localparam int unsigned      RK_W    = bits_for(RACKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [KEY_W-1:0]  wr_key,
   input  logic [SH_W-1:0]   wr_shelf,
   input  logic [RK_W-1:0]   wr_rack,
   input  logic              q_en,
   input  logic [KEY_W-1:0]  q_key,
   output logic              done,
   output logic              not_found,
   output logic [SH_W-1:0]   shelf_o,
   output logic [RK_W-1:0]   rack_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              wr_reject
);
   localparam int unsigned VEC_W = bits_for(SHELVES * RACKS);

   generate
      if (SHELVES < 1 || RACKS < 1) begin : g_bad_layout
         $error("loc_catalog: layout needs at least one shelf and one rack");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("loc_catalog: DEPTH must be at least 2");
      end
      if (VEC_W + SLOT_LG > ADDR_W) begin : g_bad_addr
         $error("loc_catalog: table offset does not fit in ADDR_W");
      end
   endgenerate

   logic             loc_ok;
   logic [VEC_W-1:0] wr_vec;
   logic             wr_accept;
   logic             q_hit;
   logic [VEC_W-1:0] q_vec;
   logic [SH_W-1:0]  dec_shelf;
   logic [RK_W-1:0]  dec_rack;
   logic [ADDR_W-1:0] dec_addr;

   loc_vec_enc #(.SHELVES(SHELVES), .RACKS(RACKS), .SH_W(SH_W), .RK_W(RK_W),
                 .VEC_W(VEC_W)) u_enc (
      .shelf_in(wr_shelf), .rack_in(wr_rack), .loc_ok(loc_ok), .vec_out(wr_vec));

   loc_cat_store #(.DEPTH(DEPTH), .KEY_W(KEY_W), .VEC_W(VEC_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_key(wr_key), .wr_vec(wr_vec),
      .wr_loc_ok(loc_ok), .q_key(q_key), .wr_accept(wr_accept),
      .q_hit(q_hit), .q_vec(q_vec));

   loc_vec_dec #(.SHELVES(SHELVES), .RACKS(RACKS), .SH_W(SH_W), .RK_W(RK_W),
                 .VEC_W(VEC_W), .ADDR_W(ADDR_W), .SLOT_LG(SLOT_LG),
                 .BASE(BASE)) u_dec (
      .vec_in(q_vec), .shelf_out(dec_shelf), .rack_out(dec_rack),
      .addr_out(dec_addr));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done      <= 1'b0;
         not_found <= 1'b0;
         shelf_o   <= '0;
         rack_o    <= '0;
         addr_o    <= '0;
         wr_reject <= 1'b0;
      end else begin
         done      <= q_en;
         wr_reject <= wr_en && !wr_accept;
         if (q_en) begin
            not_found <= !q_hit;
            shelf_o   <= q_hit ? dec_shelf : '0;
            rack_o    <= q_hit ? dec_rack  : '0;
            addr_o    <= q_hit ? dec_addr  : '0;
         end
      end
   end
endmodule

// File: rtl/loc_catalog_chk.sv
`timescale 1ns/1ps
module loc_catalog_chk #(
   parameter int unsigned       RACKS  = 3,
   parameter int unsigned       SH_W   = 2,
   parameter int unsigned       RK_W   = 2,
   parameter int unsigned       ADDR_W = 32,
   parameter int unsigned       SLOT_LG = 2,
   parameter logic [ADDR_W-1:0] BASE   = 32'hFFF0_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              q_en,
   input logic              done,
   input logic              not_found,
   input logic [SH_W-1:0]   shelf_o,
   input logic [RK_W-1:0]   rack_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic              wr_reject
);
   // R5: an answer strobe follows every request
   a_r5_done_after_query: assert property (@(posedge clk) disable iff (!rst_n)
      q_en |=> done);
   // R5: no strobe without a request
   a_r5_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
      !q_en |=> !done);
   // R6: a miss carries zeroed location and address
   a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && not_found) |-> (shelf_o == '0 && rack_o == '0 && addr_o == '0));
   // R4: a hit's address matches its shelf and rack
   a_r4_addr_formula: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !not_found) |->
      (addr_o == BASE + (ADDR_W'((int'(shelf_o) - 1) * int'(RACKS) + int'(rack_o))
                         << SLOT_LG)));
   // R10: answers hold while no request arrives
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !q_en |=> ($stable(shelf_o) && $stable(rack_o) && $stable(addr_o) &&
                 $stable(not_found)));
   // R8: a reject only follows a write
   a_r8_reject_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reject |-> $past(wr_en));
endmodule

bind loc_catalog loc_catalog_chk #(
   .RACKS(RACKS), .SH_W(SH_W), .RK_W(RK_W), .ADDR_W(ADDR_W),
   .SLOT_LG(SLOT_LG), .BASE(BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .q_en(q_en), .done(done),
   .not_found(not_found), .shelf_o(shelf_o), .rack_o(rack_o),
   .addr_o(addr_o), .wr_reject(wr_reject)
);

// File: tb/loc_catalog_bench.sv
`timescale 1ns/1ps
module loc_catalog_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_key = '0;
   logic [1:0]  wr_shelf = '0;
   logic [1:0]  wr_rack = '0;
   logic        q_en = 1'b0;
   logic [7:0]  q_key = '0;
   logic        done, not_found, wr_reject;
   logic [1:0]  shelf_o, rack_o;
   logic [31:0] addr_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   loc_catalog u_loc_catalog (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_key(wr_key),
      .wr_shelf(wr_shelf), .wr_rack(wr_rack), .q_en(q_en), .q_key(q_key),
      .done(done), .not_found(not_found), .shelf_o(shelf_o), .rack_o(rack_o),
      .addr_o(addr_o), .wr_reject(wr_reject));

   function automatic logic [31:0] exp_addr(input int s, input int r);
      return 32'hFFF0_0000 + 32'(4 * ((s - 1) * 3 + r));
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   // Drives one cycle of stimulus; samples on the following falling edge.
   task automatic cycle(input bit we, input logic [7:0] wk, input int ws, input int wrk,
                        input bit qe, input logic [7:0] qk);
      @(negedge clk);
      wr_en = we; wr_key = wk; wr_shelf = 2'(ws); wr_rack = 2'(wrk);
      q_en = qe; q_key = qk;
      @(negedge clk);
      wr_en = 1'b0; q_en = 1'b0;
   endtask

   task automatic write_loc(input string req, input logic [7:0] k, input int s,
                            input int r, input bit exp_rej);
      cycle(1'b1, k, s, r, 1'b0, 8'd0);
      chk(wr_reject == exp_rej, req, "wr_reject", 32'(wr_reject), 32'(exp_rej));
   endtask

   task automatic expect_answer(input string req, input bit found, input int s,
                                input int r);
      chk(done == 1'b1, req, "done", 32'(done), 32'd1);
      chk(not_found == !found, req, "not_found", 32'(not_found), 32'(!found));
      chk(shelf_o == (found ? 2'(s) : 2'd0), req, "shelf", 32'(shelf_o),
          found ? 32'(s) : 32'd0);
      chk(rack_o == (found ? 2'(r) : 2'd0), req, "rack", 32'(rack_o),
          found ? 32'(r) : 32'd0);
      chk(addr_o == (found ? exp_addr(s, r) : 32'd0), req, "addr", addr_o,
          found ? exp_addr(s, r) : 32'd0);
   endtask

   task automatic query(input string req, input logic [7:0] k, input bit found,
                        input int s, input int r);
      cycle(1'b0, 8'd0, 0, 0, 1'b1, k);
      expect_answer(req, found, s, r);
   endtask

   task automatic t_reset;
      chk(done == 1'b0, "R1", "done", 32'(done), 0);
      chk(not_found == 1'b0, "R1", "not_found", 32'(not_found), 0);
      chk(wr_reject == 1'b0, "R1", "wr_reject", 32'(wr_reject), 0);
      chk(shelf_o == 0 && rack_o == 0, "R1", "location", 32'({shelf_o, rack_o}), 0);
      chk(addr_o == 0, "R1", "addr", addr_o, 0);
      query("R1", 8'd5, 1'b0, 0, 0);
   endtask

   task automatic t_store;
      write_loc("R2", 8'd10, 1, 1, 1'b0);
      write_loc("R2", 8'd20, 1, 2, 1'b0);
      write_loc("R2", 8'd30, 3, 3, 1'b0);
      query("R4", 8'd10, 1'b1, 1, 1);
      chk(addr_o == 32'hFFF0_0004, "R4", "vector 1 address", addr_o, 32'hFFF0_0004);
      query("R4", 8'd20, 1'b1, 1, 2);
      chk(addr_o == 32'hFFF0_0008, "R4", "vector 2 address", addr_o, 32'hFFF0_0008);
      query("R2", 8'd30, 1'b1, 3, 3);
   endtask

   task automatic t_move;
      write_loc("R3", 8'd10, 2, 3, 1'b0);
      query("R3", 8'd10, 1'b1, 2, 3);
   endtask

   task automatic t_pulse_hold;
      query("R5", 8'd20, 1'b1, 1, 2);
      @(negedge clk);
      chk(done == 1'b0, "R5", "done one cycle", 32'(done), 0);
      chk(shelf_o == 2'd1 && rack_o == 2'd2, "R10", "held location",
          32'({shelf_o, rack_o}), 32'({2'd1, 2'd2}));
      chk(addr_o == exp_addr(1, 2), "R10", "held addr", addr_o, exp_addr(1, 2));
   endtask

   task automatic t_miss;
      query("R6", 8'd99, 1'b0, 0, 0);
   endtask

   task automatic t_same_cycle;
      cycle(1'b1, 8'd10, 3, 1, 1'b1, 8'd10);
      expect_answer("R7", 1'b1, 3, 1);
      cycle(1'b1, 8'd40, 2, 2, 1'b1, 8'd40);
      expect_answer("R7", 1'b1, 2, 2);
   endtask

   task automatic t_bad_loc;
      write_loc("R9", 8'd10, 0, 2, 1'b1);
      write_loc("R9", 8'd10, 2, 0, 1'b1);
      query("R9", 8'd10, 1'b1, 3, 1);
   endtask

   task automatic t_full;
      for (int i = 0; i < 12; i++) write_loc("R2", 8'(100 + i), (i % 3) + 1, 1, 1'b0);
      write_loc("R8", 8'd200, 1, 1, 1'b1);
      query("R8", 8'd200, 1'b0, 0, 0);
      write_loc("R3", 8'd20, 2, 2, 1'b0);
      query("R3", 8'd20, 1'b1, 2, 2);
      cycle(1'b1, 8'd201, 1, 3, 1'b1, 8'd201);
      chk(wr_reject == 1'b1, "R8", "full reject", 32'(wr_reject), 1);
      expect_answer("R8", 1'b0, 0, 0);
      query("R2", 8'd111, 1'b1, 3, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_store();
      t_move();
      t_pulse_hold();
      t_miss();
      t_same_cycle();
      t_bad_loc();
      t_full();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule